// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (SCL clock, open-drain SDA) that lets a bus master read and write a small bank of byte-wide configuration registers, such as output-enable bits. Each register holds its own default value from reset. A system that never talks to the block therefore keeps a known configuration, and bus access is optional. The register contents are available in parallel on `cfg_q` so that neighbouring logic can use them directly.

The master first sends the write form of the device address. Next comes a command byte. Its top bit chooses the access mode. When that bit is 1, the transfer is an indexed single-byte access. When it is 0, the transfer is a block access that always starts at register 0 and climbs upward. A block write carries a byte count ahead of its data. A block read returns the register count first and then the registers in order. For a read, the master issues a repeated START with the read form of the address, and the slave answers using the most recent command. Both lines pass through synchronisers and a stability filter inside the block's clock domain. All bus events (START, STOP, clock edges) are detected on the filtered lines.

The control FSM has nine states:
- IDLE: the bus is free.
- ADDR: the address byte is shifting in.
- CMD: the command byte is shifting in.
- COUNT: the block-write byte count is shifting in.
- WDATA: write data is shifting in.
- ACK: the slave holds SDA low for one bit.
- TX: the slave shifts a byte out.
- TACK: the slave samples the master's acknowledge.
- IGNORE: the slave waits for the next START or STOP.

The transitions are:
- START from any state goes to ADDR, and STOP from any state goes to IDLE.
- ADDR goes to ACK on a match and to IGNORE otherwise.
- CMD, COUNT and WDATA go to ACK after eight bits.
- ACK goes to its saved follow-on state: CMD, COUNT, WDATA or TX.
- TX goes to TACK after eight bits.
- TACK goes back to TX when the master acknowledges, and to IGNORE when it does not.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, register i holds RST_BASE + i (default 0xC0 + i), `cfg_q` byte i (bits 8i+7:8i) shows register i, and `sda_oe` is 0.
- R2: The slave acknowledges an address byte only when its upper seven bits equal DEV_ADDR (default 0x69, so 0xD2 to write and 0xD3 to read). On any other address it does not acknowledge, and it neither acknowledges nor acts on further bytes until the next START.
- R3: After a matching address, the slave acknowledges the command byte, the count byte and every write data byte, including data bytes it discards.
- R4: A command with bit 7 = 1 selects a single-byte write to the register indexed by bits 6:0. Only the first data byte is stored. Later bytes, and any index at or above NUM_REGS, leave the registers unchanged.
- R5: After a single-byte command, a repeated START with the read address returns the indexed register, MSB first. An index at or above NUM_REGS reads as 0x00.
- R6: A command with bit 7 = 0 selects a block write. The next byte is a count, and the data bytes that follow go into registers 0, 1, 2 and so on. Data beyond the count, or beyond the last register, is discarded.
- R7: A block read returns NUM_REGS first, then registers 0 upward, MSB first. Positions past the last register read as 0x00, and the slave stops driving after the master does not acknowledge.
- R8: A block write ended by STOP after any complete byte keeps the bytes already received and leaves the rest unchanged.
- R9: A read address with no new command reuses the last command code. After reset, the last command counts as a block access.
- R10: The slave releases SDA in IDLE and IGNORE, and a STOP always returns it to IDLE.
- R11: A pulse on SCL shorter than FILT_CYCLES system clocks is not counted as a bit.
- R12: The slave changes SDA only while filtered SCL is low, so a driven bit stays stable through the whole high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_q | output | NUM_REGS*8 | Parallel view of all registers, register i in bits 8i+7:8i |

## Verification
Every slave response is registered one system clock after the filtered SCL falling edge. That edge itself lags the pin by SYNC_STAGES + FILT_CYCLES clocks, so an ACK or data bit appears roughly 8 clocks after the master lowers SCL. The bench lowers SCL, waits two quarter periods of 10 clocks each, and then samples SDA twice during the high phase, once just after the rise and once just before the fall. A register write lands about 8 clocks after the eighth falling edge of its data byte. The bench compares `cfg_q` with its model only after the STOP, which is several quarter periods later.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_CMD,
        S_COUNT,
        S_WDATA,
        S_ACK,
        S_TX,
        S_TACK,
        S_IGNORE
    } cfgs_state_e;

endpackage

// File: rtl/cfgs_line_filter.sv
module cfgs_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   raw;

    assign raw = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            cnt_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            if (raw == line_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_W'(FILT_CYCLES - 1)) begin
                line_o <= raw;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/cfgs_bus_events.sv
module cfgs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign start_evt = scl_f && scl_q && sda_q && !sda_f;
    assign stop_evt  = scl_f && scl_q && !sda_q && sda_f;
    assign scl_rise  = scl_f && !scl_q;
    assign scl_fall  = !scl_f && scl_q;
endmodule

// File: rtl/cfgs_regbank.sv
module cfgs_regbank #(
    parameter int         NUM_REGS = 8,
    parameter logic [7:0] RST_BASE = 8'hC0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [7:0]            waddr,
    input  logic [7:0]            wdata,
    input  logic [7:0]            raddr,
    output logic [7:0]            rdata,
    output logic [NUM_REGS*8-1:0] q_flat
);
    logic [7:0] regs_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[i] <= RST_BASE + 8'(i);
            end else if (we && waddr == 8'(i)) begin
                regs_q[i] <= wdata;
            end
        end
        assign q_flat[i*8 +: 8] = regs_q[i];
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr == 8'(i)) rdata = regs_q[i];
        end
    end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfgs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 8,
    parameter logic [7:0] RST_BASE    = 8'hC0,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_q
);
    localparam logic [7:0] NREG8 = 8'(NUM_REGS);

    logic [1:0] raw_in;
    logic [1:0] filt_out;
    logic       scl_f, sda_f;
    logic       start_evt, stop_evt, scl_rise, scl_fall;

    assign raw_in = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        cfgs_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_CYCLES(FILT_CYCLES)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_in[g]),
            .line_o(filt_out[g])
        );
    end

    assign scl_f = filt_out[1];
    assign sda_f = filt_out[0];

    cfgs_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    cfgs_state_e state_q, state_d, after_q;
    logic [3:0]  bitcnt_q;
    logic [7:0]  shreg_q, txsh_q;
    logic        cmd_blk_q;
    logic [6:0]  cmd_idx_q;
    logic [7:0]  wr_ptr_q, cnt_left_q, rd_ptr_q;
    logic        m_ack_q, sda_oe_q;
    logic        done8, addr_hit, rb_we;
    logic [7:0]  rb_waddr, rb_raddr, rb_rdata;

    assign done8    = scl_fall && (bitcnt_q == 4'd8);
    assign addr_hit = (shreg_q[7:1] == DEV_ADDR);
    assign rb_we    = (state_q == S_WDATA) && done8 &&
                      (cnt_left_q != 8'd0) && (wr_ptr_q < NREG8);
    assign rb_waddr = wr_ptr_q;
    assign rb_raddr = (state_q == S_ADDR) ? {1'b0, cmd_idx_q} : rd_ptr_q;

    cfgs_regbank #(
        .NUM_REGS(NUM_REGS),
        .RST_BASE(RST_BASE)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rb_we),
        .waddr (rb_waddr),
        .wdata (shreg_q),
        .raddr (rb_raddr),
        .rdata (rb_rdata),
        .q_flat(cfg_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_evt) begin
            state_d = S_ADDR;
        end else if (stop_evt) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE, S_IGNORE: state_d = state_q;
                S_ADDR:  if (done8) state_d = addr_hit ? S_ACK : S_IGNORE;
                S_CMD, S_COUNT, S_WDATA:
                         if (done8) state_d = S_ACK;
                S_ACK:   if (scl_fall) state_d = after_q;
                S_TX:    if (scl_fall && bitcnt_q == 4'd7) state_d = S_TACK;
                S_TACK:  if (scl_fall) state_d = m_ack_q ? S_TX : S_IGNORE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            after_q    <= S_IDLE;
            bitcnt_q   <= '0;
            shreg_q    <= '0;
            txsh_q     <= '0;
            cmd_blk_q  <= 1'b1;
            cmd_idx_q  <= '0;
            wr_ptr_q   <= '0;
            cnt_left_q <= '0;
            rd_ptr_q   <= '0;
            m_ack_q    <= 1'b0;
            sda_oe_q   <= 1'b0;
        end else if (start_evt || stop_evt) begin
            bitcnt_q <= '0;
            sda_oe_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_ADDR, S_CMD, S_COUNT, S_WDATA: begin
                    if (scl_rise) begin
                        shreg_q  <= {shreg_q[6:0], sda_f};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end
                    if (done8) begin
                        bitcnt_q <= '0;
                        sda_oe_q <= (state_q != S_ADDR) || addr_hit;
                        if (state_q == S_ADDR) begin
                            if (shreg_q[0]) begin
                                after_q  <= S_TX;
                                txsh_q   <= cmd_blk_q ? NREG8 : rb_rdata;
                                rd_ptr_q <= cmd_blk_q ? 8'd0 : ({1'b0, cmd_idx_q} + 8'd1);
                            end else begin
                                after_q <= S_CMD;
                            end
                        end else if (state_q == S_CMD) begin
                            cmd_blk_q  <= ~shreg_q[7];
                            cmd_idx_q  <= shreg_q[6:0];
                            cnt_left_q <= 8'd1;
                            wr_ptr_q   <= shreg_q[7] ? {1'b0, shreg_q[6:0]} : 8'd0;
                            after_q    <= shreg_q[7] ? S_WDATA : S_COUNT;
                        end else if (state_q == S_COUNT) begin
                            cnt_left_q <= shreg_q;
                            after_q    <= S_WDATA;
                        end else begin
                            if (cnt_left_q != 8'd0) cnt_left_q <= cnt_left_q - 8'd1;
                            if (wr_ptr_q != 8'hFF)  wr_ptr_q   <= wr_ptr_q + 8'd1;
                            after_q <= S_WDATA;
                        end
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        bitcnt_q <= '0;
                        sda_oe_q <= (after_q == S_TX) ? ~txsh_q[7] : 1'b0;
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (bitcnt_q == 4'd7) begin
                            bitcnt_q <= '0;
                            sda_oe_q <= 1'b0;
                        end else begin
                            bitcnt_q <= bitcnt_q + 4'd1;
                            txsh_q   <= {txsh_q[6:0], 1'b0};
                            sda_oe_q <= ~txsh_q[6];
                        end
                    end
                end
                S_TACK: begin
                    if (scl_rise) m_ack_q <= ~sda_f;
                    if (scl_fall) begin
                        if (m_ack_q) begin
                            txsh_q   <= rb_rdata;
                            sda_oe_q <= ~rb_rdata[7];
                            if (rd_ptr_q != 8'hFF) rd_ptr_q <= rd_ptr_q + 8'd1;
                        end else begin
                            sda_oe_q <= 1'b0;
                        end
                    end
                end
                default: sda_oe_q <= 1'b0;
            endcase
        end
    end

    assign sda_oe = sda_oe_q;

endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker
    import cfgs_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_f,
    input logic        sda_oe,
    input cfgs_state_e state_q,
    input logic        stop_evt,
    input logic        rb_we,
    input logic [7:0]  rb_waddr
);
    // R12
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE || state_q == S_IGNORE) |-> !sda_oe);

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state_q == S_IDLE));

    // R6
    we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_we |-> (rb_waddr < 8'(NUM_REGS)));

    // R3
    write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_we |=> sda_oe);
endmodule

bind cfg_serial_slave cfgs_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_oe  (sda_oe_q),
    .state_q (state_q),
    .stop_evt(stop_evt),
    .rb_we   (rb_we),
    .rb_waddr(rb_waddr)
);

// File: tb/cfg_serial_slave_test.sv
module cfg_serial_slave_test;
    localparam int         N    = 8;
    localparam logic [7:0] BASE = 8'hC0;
    localparam int         Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic [N*8-1:0] cfg_q;
    wire  sda_line = m_sda & ~sda_oe;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [7:0] mdl [N];
    bit last_blk = 1;
    logic [6:0] last_idx = '0;

    always #10 clk = ~clk;

    cfg_serial_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .cfg_q(cfg_q)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N*8-1:0] mdl_flat();
        logic [N*8-1:0] v;
        for (int i = 0; i < N; i++) v[i*8 +: 8] = mdl[i];
        return v;
    endfunction

    function automatic logic [7:0] mdl_rd(input int idx);
        return (idx < N) ? mdl[idx] : 8'h00;
    endfunction

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b1; qwait(); qwait();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; qwait();
        m_scl = 1'b1; qwait(); qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic recv_bit(output logic b);
        logic b0, b1;
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        b0 = sda_line; qwait();
        b1 = sda_line;
        m_scl = 1'b0; qwait();
        chk("R12 bit stable while SCL high", 64'(b1), 64'(b0));
        b = b0;
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack, input bit glitch = 0);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            send_bit(v[i]);
            if (glitch && i == 4) begin
                m_scl = 1'b1; repeat (2) @(negedge clk); m_scl = 1'b0; qwait();
            end
        end
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(output logic [7:0] v, input bit mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~mack);
    endtask

    task automatic byte_write(input logic [6:0] idx, input logic [7:0] d, input int extra);
        logic ack;
        bus_start();
        write_byte(8'hD2, ack); chk("R2 write address ack", 64'(ack), 64'd1);
        write_byte({1'b1, idx}, ack); chk("R3 command ack", 64'(ack), 64'd1);
        write_byte(d, ack); chk("R3 data ack", 64'(ack), 64'd1);
        for (int e = 0; e < extra; e++) begin
            write_byte(8'(~d + 8'(e)), ack); chk("R3 extra byte ack", 64'(ack), 64'd1);
        end
        bus_stop();
        last_blk = 0; last_idx = idx;
        if (int'(idx) < N) mdl[idx] = d;
        chk("R4 registers after single-byte write", 64'(cfg_q), 64'(mdl_flat()));
    endtask

    task automatic byte_read(input logic [6:0] idx);
        logic ack;
        logic [7:0] v;
        bus_start();
        write_byte(8'hD2, ack); chk("R2 address ack", 64'(ack), 64'd1);
        write_byte({1'b1, idx}, ack); chk("R3 command ack", 64'(ack), 64'd1);
        bus_start();
        write_byte(8'hD3, ack); chk("R2 read address ack", 64'(ack), 64'd1);
        read_byte(v, 0);
        bus_stop();
        last_blk = 0; last_idx = idx;
        chk("R5 single-byte read value", 64'(v), 64'(mdl_rd(int'(idx))));
        chk("R10 SDA released after stop", 64'(sda_oe), 64'd0);
    endtask

    task automatic block_write(input logic [7:0] cnt, input int nb);
        logic ack;
        logic [7:0] d;
        int ptr;
        int c;
        bus_start();
        write_byte(8'hD2, ack); chk("R2 address ack", 64'(ack), 64'd1);
        write_byte(8'h00, ack); chk("R3 block command ack", 64'(ack), 64'd1);
        write_byte(cnt, ack); chk("R3 count ack", 64'(ack), 64'd1);
        ptr = 0; c = int'(cnt);
        for (int j = 0; j < nb; j++) begin
            d = 8'($urandom);
            write_byte(d, ack); chk("R3 block data ack", 64'(ack), 64'd1);
            if (c > 0 && ptr < N) begin mdl[ptr] = d; c--; end
            ptr++;
        end
        bus_stop();
        last_blk = 1; last_idx = '0;
        chk("R6 registers after block write", 64'(cfg_q), 64'(mdl_flat()));
    endtask

    task automatic block_read(input int k, input bit with_cmd);
        logic ack;
        logic [7:0] v;
        bus_start();
        if (with_cmd) begin
            write_byte(8'hD2, ack); chk("R2 address ack", 64'(ack), 64'd1);
            write_byte(8'h00, ack); chk("R3 block command ack", 64'(ack), 64'd1);
            bus_start();
            last_blk = 1; last_idx = '0;
        end
        write_byte(8'hD3, ack); chk("R2 read address ack", 64'(ack), 64'd1);
        read_byte(v, k > 0);
        chk("R7 block read count byte", 64'(v), 64'(N));
        for (int j = 0; j < k; j++) begin
            read_byte(v, j < k - 1);
            chk("R7 block read data", 64'(v), 64'(mdl_rd(j)));
        end
        bus_stop();
        chk("R10 SDA released after stop", 64'(sda_oe), 64'd0);
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic ack;
        logic [7:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) mdl[i] = BASE + 8'(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk("R1 reset register defaults", 64'(cfg_q), 64'(mdl_flat()));
        chk("R1 SDA released at reset", 64'(sda_oe), 64'd0);

        // R9 read without command after reset acts as block read
        bus_start();
        write_byte(8'hD3, ack); chk("R9 read address ack", 64'(ack), 64'd1);
        read_byte(v, 1); chk("R9 count byte after reset", 64'(v), 64'(N));
        read_byte(v, 0); chk("R9 first register after reset", 64'(v), 64'(BASE));
        bus_stop();

        // R2 foreign address ignored
        bus_start();
        write_byte(8'hA4, ack); chk("R2 foreign address nack", 64'(ack), 64'd0);
        write_byte(8'h81, ack); chk("R2 command ignored", 64'(ack), 64'd0);
        write_byte(8'h11, ack); chk("R2 data ignored", 64'(ack), 64'd0);
        bus_stop();
        chk("R2 registers unchanged", 64'(cfg_q), 64'(mdl_flat()));

        // R4 single-byte write with trailing bytes, and out of range
        byte_write(7'd3, 8'h5A, 2);
        byte_write(7'h50, 8'h33, 0);

        // R5 single-byte read, in and out of range
        byte_read(7'd3);
        byte_read(7'h40);

        // R9 repeat read reuses the single-byte command
        bus_start();
        write_byte(8'hD3, ack); chk("R9 read address ack", 64'(ack), 64'd1);
        read_byte(v, 0); chk("R9 reused index 0x40 reads zero", 64'(v), 64'd0);
        bus_stop();

        // R6 block write bounded by count, then by register count
        block_write(8'd3, 5);
        block_write(8'd20, N + 2);

        // R8 block write stopped early
        block_write(8'd5, 2);
        chk("R8 untouched registers kept", 64'(cfg_q[N*8-1:16]), 64'(mdl_flat() >> 16));

        // R7 block read past the end
        block_read(N + 2, 1);

        // R11 short SCL glitch inside a data byte
        bus_start();
        write_byte(8'hD2, ack);
        write_byte(8'h85, ack);
        write_byte(8'hC3, ack, 1); chk("R11 ack despite glitch", 64'(ack), 64'd1);
        bus_stop();
        mdl[5] = 8'hC3; last_blk = 0; last_idx = 7'd5;
        chk("R11 glitch not counted as a bit", 64'(cfg_q), 64'(mdl_flat()));

        // constrained random mix
        for (int t = 0; t < 16; t++) begin
            int kind;
            kind = int'($urandom % 4);
            case (kind)
                0: byte_write(7'($urandom % (N + 3)), 8'($urandom), int'($urandom % 2));
                1: byte_read(7'($urandom % (N + 3)));
                2: block_write(8'($urandom % (N + 3)), 1 + int'($urandom % (N + 2)));
                default: block_read(int'($urandom % (N + 3)), 1);
            endcase
        end

        chk("R10 SDA released at end", 64'(sda_oe), 64'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule